// File: doc/BRIEF.md
# UART Oversampling Receiver

This block turns an asynchronous serial line into parallel characters. It runs on the system clock. A 16x oversampling enable (`tick16`) paces it, and that enable has no tie to any transmit-side timing. The line first passes through a two-flop synchronizer. When the receiver sees a low level on the idle line, it confirms that level at mid-start-bit. It then samples every data bit at its centre, which falls 1.5 bit times after the edge and one bit time apart after that. It checks the optional parity bit and the first stop bit, then loads the result into a receive buffer register.

Status comes out as level signals: data ready, an active-low receive-ready handshake, and sticky overrun, parity, framing and break flags. The host clears data ready with a buffer read strobe. It clears the four error flags with a line-status read strobe. The word length and parity settings come from a line-control register outside this block and must stay stable while a character is being received.

Top module: `uart_rx_core`

## Requirements
- R1: After reset, `data_ready`, `overrun_err`, `parity_err`, `framing_err` and `break_int` are 0, `rx_rdy_n` is 1 and `rbr_data` is 00h.
- R2: A low level seen on a `tick16` while idle starts a character. If the synchronized line is high again 8 ticks later (mid start bit), the start is treated as false: the receiver returns to idle, and no character, flag or `data_ready` change results.
- R3: Data bits are sampled 24, 40, 56, … ticks after the detecting tick, least significant bit first. `word_len` selects 5, 6, 7 or 8 bits for codes 0, 1, 2 and 3. Buffer bits above the word length read 0.
- R4: When `parity_en` is 1, one parity bit follows the data. With `parity_even`=1 the data and parity together must hold an even number of ones; with `parity_even`=0, an odd number. A mismatch sets `parity_err`.
- R5: Only the first stop bit is sampled. A low level there sets `framing_err`, and the character is still loaded. Frames with one or two stop bits are received back to back.
- R6: If every sampled bit of a frame is low, including the stop bit, the frame is a break: `break_int` and `framing_err` are set and `rbr_data` is loaded with 00h.
- R7: After a low stop-bit sample, no new start is detected until the line has been seen high. A held break therefore yields exactly one character.
- R8: Each completed character loads `rbr_data`, sets `data_ready` and drives `rx_rdy_n` low in the cycle after the stop sample.
- R9: A `rbr_rd` pulse clears `data_ready` and returns `rx_rdy_n` to 1. If a character completes in the same cycle, `data_ready` stays 1.
- R10: A character that completes while `data_ready` is 1 and no read is under way sets `overrun_err` and overwrites the buffer.
- R11: A `lsr_rd` pulse clears `overrun_err`, `parity_err`, `framing_err` and `break_int`. An error from a character completing in the same cycle stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick16 | input | 1 | Receive enable, 16 pulses per bit time |
| rx_serial | input | 1 | Asynchronous serial input, idle high |
| word_len | input | 2 | Data bits: 0=5, 1=6, 2=7, 3=8 |
| parity_en | input | 1 | 1 = parity bit follows data |
| parity_even | input | 1 | 1 = even parity, 0 = odd |
| rbr_rd | input | 1 | One-cycle read strobe of the receive buffer |
| lsr_rd | input | 1 | One-cycle read strobe of the line status |
| rbr_data | output | 8 | Receive buffer register |
| data_ready | output | 1 | A character is waiting |
| rx_rdy_n | output | 1 | Active-low receive handshake, low while a character waits |
| overrun_err | output | 1 | Sticky overrun flag |
| parity_err | output | 1 | Sticky parity error flag |
| framing_err | output | 1 | Sticky framing error flag |
| break_int | output | 1 | Sticky break flag |

## Verification
The assertions watch the buffer and flag updates on every cycle. They check that each completed character sets data ready and loads the buffer, and that an unread buffer turns into an overrun. They also check that the read strobes clear their flags, that a break always leaves 00h in the buffer, that a false start returns to idle, and that the bit index never passes the word length. Only the bench scenarios can show that the bits are taken at their centres and in the right order. The same holds for the 1.5-bit first-sample offset, the parity sense, short glitches being rejected, and the receiver waiting for the line to go high after a break.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int unsigned DATA_W   = 8;
  localparam int unsigned MIN_BITS = 5;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_HOLD
  } rx_state_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              perr;
    logic              ferr;
    logic              brk;
  } rx_char_t;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '1;
    else        stage_q <= {stage_q[STAGES-2:0], din};
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx,
  input  logic [1:0] word_len,
  input  logic       par_en,
  input  logic       par_even,
  output logic       done,
  output rx_char_t   chr
);

  localparam int unsigned CNT_W = $clog2(OVS);
  localparam int unsigned IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVS/2 - 1);
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OVS - 1);

  rx_state_e         state_q, state_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic [DATA_W-1:0] sh_q, sh_n;
  logic              par_q, par_n;
  logic              zero_q, zero_n;
  logic              perr_q, perr_n;
  logic [IDX_W-1:0]  last_idx;
  logic              sample;

  assign last_idx = IDX_W'(word_len) + IDX_W'(MIN_BITS - 1);
  assign sample   = tick && (cnt_q == FULL_LAST);

  always_comb begin
    state_n  = state_q;
    cnt_n    = cnt_q;
    idx_n    = idx_q;
    sh_n     = sh_q;
    par_n    = par_q;
    zero_n   = zero_q;
    perr_n   = perr_q;
    done     = 1'b0;
    chr.data = sh_q;
    chr.perr = perr_q;
    chr.ferr = !rx;
    chr.brk  = zero_q && !rx;
    if (zero_q && !rx) chr.data = '0;
    if (tick && state_q != RX_IDLE && state_q != RX_HOLD) cnt_n = cnt_q + 1'b1;
    unique case (state_q)
      RX_IDLE: begin
        if (tick && !rx) begin
          state_n = RX_START;
          cnt_n   = '0;
          idx_n   = '0;
          sh_n    = '0;
          par_n   = 1'b0;
          zero_n  = 1'b1;
          perr_n  = 1'b0;
        end
      end
      RX_START: begin
        if (tick && cnt_q == HALF_LAST) begin
          cnt_n   = '0;
          state_n = rx ? RX_IDLE : RX_DATA;
        end
      end
      RX_DATA: begin
        if (sample) begin
          sh_n[idx_q] = rx;
          par_n       = par_q ^ rx;
          zero_n      = zero_q && !rx;
          if (idx_q == last_idx) state_n = par_en ? RX_PAR : RX_STOP;
          else                   idx_n   = idx_q + 1'b1;
        end
      end
      RX_PAR: begin
        if (sample) begin
          perr_n  = par_q ^ rx ^ !par_even;
          zero_n  = zero_q && !rx;
          state_n = RX_STOP;
        end
      end
      RX_STOP: begin
        if (sample) begin
          done    = 1'b1;
          state_n = rx ? RX_IDLE : RX_HOLD;
        end
      end
      RX_HOLD: begin
        if (tick && rx) state_n = RX_IDLE;
      end
      default: state_n = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      zero_q  <= 1'b0;
      perr_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      idx_q   <= idx_n;
      sh_q    <= sh_n;
      par_q   <= par_n;
      zero_q  <= zero_n;
      perr_q  <= perr_n;
    end
  end

  // R2: a start bit that is high again at its midpoint is dropped
  a_r2_false_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_START && tick && cnt_q == HALF_LAST && rx) |=> state_q == RX_IDLE);

  // R3: the bit index never passes the selected word length
  a_r3_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_DATA) |-> (idx_q <= last_idx));

  // R7: after a low stop sample the receiver holds off until the line is high
  a_r7_hold_after_low_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_STOP && sample && !rx) |=> state_q == RX_HOLD);

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  rx_char_t          chr,
  input  logic              rbr_rd,
  input  logic              lsr_rd,
  output logic [DATA_W-1:0] rbr,
  output logic              dr,
  output logic              oe,
  output logic              pe,
  output logic              fe,
  output logic              bi
);

  logic [DATA_W-1:0] rbr_n;
  logic              dr_n, oe_n, pe_n, fe_n, bi_n;

  always_comb begin
    rbr_n = rbr;
    dr_n  = dr;
    oe_n  = oe;
    pe_n  = pe;
    fe_n  = fe;
    bi_n  = bi;
    if (rbr_rd) dr_n = 1'b0;
    if (lsr_rd) begin
      oe_n = 1'b0;
      pe_n = 1'b0;
      fe_n = 1'b0;
      bi_n = 1'b0;
    end
    if (done) begin
      rbr_n = chr.data;
      dr_n  = 1'b1;
      if (dr && !rbr_rd) oe_n = 1'b1;
      if (chr.perr)      pe_n = 1'b1;
      if (chr.ferr)      fe_n = 1'b1;
      if (chr.brk)       bi_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbr <= '0;
      dr  <= 1'b0;
      oe  <= 1'b0;
      pe  <= 1'b0;
      fe  <= 1'b0;
      bi  <= 1'b0;
    end else begin
      rbr <= rbr_n;
      dr  <= dr_n;
      oe  <= oe_n;
      pe  <= pe_n;
      fe  <= fe_n;
      bi  <= bi_n;
    end
  end

  // R8: a completed character is waiting in the next cycle
  a_r8_load_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (dr && rbr == $past(chr.data)));

  // R6: a break always leaves zero in the buffer
  a_r6_break_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && chr.brk) |=> (bi && fe && rbr == '0));

  // R9: a buffer read without a new character clears data ready
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rbr_rd && !done) |=> !dr);

  // R10: an unread buffer being overwritten flags an overrun
  a_r10_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (done && dr && !rbr_rd) |=> oe);

  // R11: a status read without a new character clears every error flag
  a_r11_status_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !done) |=> !(oe || pe || fe || bi));

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rx_serial,
  input  logic [1:0]        word_len,
  input  logic              parity_en,
  input  logic              parity_even,
  input  logic              rbr_rd,
  input  logic              lsr_rd,
  output logic [DATA_W-1:0] rbr_data,
  output logic              data_ready,
  output logic              rx_rdy_n,
  output logic              overrun_err,
  output logic              parity_err,
  output logic              framing_err,
  output logic              break_int
);

  logic     rx_s;
  logic     frame_done;
  rx_char_t frame_chr;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rx_serial),
    .dout (rx_s)
  );

  uart_rx_frame #(.OVS(OVS)) u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick16),
    .rx      (rx_s),
    .word_len(word_len),
    .par_en  (parity_en),
    .par_even(parity_even),
    .done    (frame_done),
    .chr     (frame_chr)
  );

  uart_rx_status u_status (
    .clk   (clk),
    .rst_n (rst_n),
    .done  (frame_done),
    .chr   (frame_chr),
    .rbr_rd(rbr_rd),
    .lsr_rd(lsr_rd),
    .rbr   (rbr_data),
    .dr    (data_ready),
    .oe    (overrun_err),
    .pe    (parity_err),
    .fe    (framing_err),
    .bi    (break_int)
  );

  assign rx_rdy_n = !data_ready;

endmodule

// File: tb/uart_rx_core_tb.sv
module uart_rx_core_tb;

  localparam int BIT_CLKS = 64;  // 16 ticks x 4 clocks

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic [1:0] tdiv = 2'd0;
  logic       rx_serial = 1'b1;
  logic [1:0] word_len = 2'd3;
  logic       parity_en = 1'b0;
  logic       parity_even = 1'b0;
  logic       rbr_rd = 1'b0;
  logic       lsr_rd = 1'b0;
  logic [7:0] rbr_data;
  logic       data_ready, rx_rdy_n, overrun_err, parity_err, framing_err, break_int;

  int vectors = 0;
  int miscompares = 0;
  logic [7:0] m_rbr = 8'h00;
  logic m_dr = 1'b0, m_oe = 1'b0, m_pe = 1'b0, m_fe = 1'b0, m_bi = 1'b0;

  always #2 clk = ~clk;

  always @(negedge clk) begin
    tdiv   <= tdiv + 2'd1;
    tick16 <= (tdiv == 2'd3);
  end

  uart_rx_core u_dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_serial(rx_serial),
    .word_len(word_len), .parity_en(parity_en), .parity_even(parity_even),
    .rbr_rd(rbr_rd), .lsr_rd(lsr_rd), .rbr_data(rbr_data), .data_ready(data_ready),
    .rx_rdy_n(rx_rdy_n), .overrun_err(overrun_err), .parity_err(parity_err),
    .framing_err(framing_err), .break_int(break_int)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check({req, " rbr"}, rbr_data, m_rbr);
    check({req, " ready"}, data_ready, m_dr);
    check({req, " rdy_n"}, rx_rdy_n, !m_dr);
    check({req, " overrun"}, overrun_err, m_oe);
    check({req, " parity"}, parity_err, m_pe);
    check({req, " framing"}, framing_err, m_fe);
    check({req, " break"}, break_int, m_bi);
  endtask

  task automatic hold_line(input logic v, input int clks);
    rx_serial = v;
    repeat (clks) @(negedge clk);
  endtask

  function automatic logic [7:0] mask_of(input int nbits);
    return 8'((9'd1 << nbits) - 9'd1);
  endfunction

  // Send one frame and update the reference model.
  task automatic send(input logic [7:0] data, input int nbits, input logic pen,
                      input logic peven, input int stops, input logic par_bad,
                      input logic stop_low);
    logic [7:0] d;
    logic pbit, brk;
    d    = data & mask_of(nbits);
    pbit = (^d) ^ !peven ^ par_bad;
    hold_line(1'b0, BIT_CLKS);
    for (int i = 0; i < nbits; i++) hold_line(d[i], BIT_CLKS);
    if (pen) hold_line(pbit, BIT_CLKS);
    hold_line(!stop_low, BIT_CLKS);
    for (int i = 1; i < stops; i++) hold_line(1'b1, BIT_CLKS);
    hold_line(1'b1, 16);
    brk = stop_low && d == 8'h00 && (!pen || !pbit);
    if (m_dr) m_oe = 1'b1;
    m_dr  = 1'b1;
    m_rbr = brk ? 8'h00 : d;
    if (pen && par_bad) m_pe = 1'b1;
    if (stop_low) m_fe = 1'b1;
    if (brk) m_bi = 1'b1;
  endtask

  task automatic set_cfg(input int nbits, input logic pen, input logic peven);
    word_len    = 2'(nbits - 5);
    parity_en   = pen;
    parity_even = peven;
  endtask

  task automatic read_rbr();
    rbr_rd = 1'b1; @(negedge clk); rbr_rd = 1'b0; @(negedge clk);
    m_dr = 1'b0;
  endtask

  task automatic read_lsr();
    lsr_rd = 1'b1; @(negedge clk); lsr_rd = 1'b0; @(negedge clk);
    m_oe = 1'b0; m_pe = 1'b0; m_fe = 1'b0; m_bi = 1'b0;
  endtask

  initial begin
    repeat (3000 * BIT_CLKS / 4) @(negedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check_all("R1 reset");

    // R3 R8: 8-bit frame, no parity
    set_cfg(8, 1'b0, 1'b0);
    send(8'hA5, 8, 1'b0, 1'b0, 1, 1'b0, 1'b0);
    check_all("R3 R8 8-bit A5");
    read_rbr();
    check_all("R9 read clears ready");

    // R3: 5-bit word, upper bits read 0
    set_cfg(5, 1'b0, 1'b0);
    send(8'hFF, 5, 1'b0, 1'b0, 2, 1'b0, 1'b0);
    check_all("R3 5-bit mask");
    read_rbr();

    // R4: even parity good, then bad; R11 clear
    set_cfg(7, 1'b1, 1'b1);
    send(8'h3B, 7, 1'b1, 1'b1, 1, 1'b0, 1'b0);
    check_all("R4 even parity ok");
    read_rbr();
    send(8'h3B, 7, 1'b1, 1'b1, 1, 1'b1, 1'b0);
    check_all("R4 even parity bad");
    set_cfg(6, 1'b1, 1'b0);
    read_rbr();
    read_lsr();
    send(8'h2A, 6, 1'b1, 1'b0, 1, 1'b1, 1'b0);
    check_all("R4 odd parity bad");
    read_lsr();
    check_all("R11 status read clears");
    read_rbr();

    // R5: low stop bit gives framing error, character kept
    set_cfg(8, 1'b0, 1'b0);
    send(8'h55, 8, 1'b0, 1'b0, 1, 1'b0, 1'b1);
    check_all("R5 framing");
    read_rbr();
    read_lsr();

    // R2: short low glitch is a false start
    hold_line(1'b0, 12);
    hold_line(1'b1, 20 * BIT_CLKS);
    check_all("R2 false start");

    // R6 R7: held break
    hold_line(1'b0, 12 * BIT_CLKS);
    m_dr = 1'b1; m_rbr = 8'h00; m_fe = 1'b1; m_bi = 1'b1;
    check_all("R6 break");
    read_rbr();
    hold_line(1'b0, 8 * BIT_CLKS);
    check_all("R7 no restart while low");
    hold_line(1'b1, 4 * BIT_CLKS);
    check_all("R7 no char on release");
    read_lsr();
    send(8'hC3, 8, 1'b0, 1'b0, 1, 1'b0, 1'b0);
    check_all("R7 resumes after break");

    // R10: second character without a read
    send(8'h7E, 8, 1'b0, 1'b0, 1, 1'b0, 1'b0);
    check_all("R10 overrun");
    read_rbr();
    read_lsr();

    // R5: two stop bits, back to back
    send(8'h01, 8, 1'b0, 1'b0, 2, 1'b0, 1'b0);
    check_all("R5 two stops first");
    read_rbr();
    send(8'h80, 8, 1'b0, 1'b0, 2, 1'b0, 1'b0);
    check_all("R5 two stops second");
    read_rbr();

    // Random frames
    for (int n = 0; n < 60; n++) begin
      int nb;
      logic pen, pev, pbad, slow;
      logic [7:0] d;
      nb   = 5 + int'($urandom_range(3, 0));
      pen  = 1'($urandom_range(1, 0));
      pev  = 1'($urandom_range(1, 0));
      pbad = pen && ($urandom_range(3, 0) == 0);
      slow = ($urandom_range(7, 0) == 0);
      d    = 8'($urandom);
      set_cfg(nb, pen, pev);
      send(d, nb, pen, pev, 1 + int'($urandom_range(1, 0)), pbad, slow);
      check_all("R3 R4 R5 R8 R10 random");
      if ($urandom_range(1, 0) == 1) begin
        read_rbr();
        check_all("R9 random read");
      end
      if ($urandom_range(3, 0) == 0) begin
        read_lsr();
        check_all("R11 random status read");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule